// File: doc/BRIEF.md
# Eight-Level Scalar Tile Decoder

This block expands a compressed 4x4 scalar tile into sixteen 8-bit values. A tile carries two 8-bit endpoints and sixteen 3-bit per-pixel selectors. The endpoints build an eight-entry palette, and each selector picks one entry. How the palette is built depends on how the two endpoints compare. If the first endpoint is the larger, all six middle entries are evenly spaced. If it is not, four middle entries are evenly spaced and the two top entries are fixed at black (0) and full scale (255).

A tile is handed over on a valid/ready handshake. The decoded values then leave one pixel per cycle in raster order, and a last flag marks the sixteenth pixel. A mode input set with the tile selects single-channel or dual-channel decoding. In dual mode the 128-bit input holds two independent 64-bit tiles, and each output beat carries both channels of one pixel. A new tile may be taken during the last beat, so consecutive tiles stream without a gap.

Top module: `scl_tile_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A tile is accepted only on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 when idle and 0 while pixels 0..14 of a tile are being output.
- R3: In the cycle after acceptance, pixel 0 appears with `out_valid` = 1. Pixels 1..15 follow in consecutive cycles. In a 64-bit channel tile, endpoint A is bits [7:0], endpoint B is bits [15:8], and pixel i selects palette entry bits [16+3i+2 : 16+3i].
- R4: `out_last` is 1 only on pixel 15. Without a new tile, `out_valid` is 0 in the cycle after it.
- R5: When A > B, entry 0 = A, entry 1 = B, and entry k (k = 2..7) = floor(((8-k)*A + (k-1)*B)/7).
- R6: When A <= B (equal included), entry 0 = A, entry 1 = B, entry k (k = 2..5) = floor(((6-k)*A + (k-1)*B)/5), entry 6 = 0 and entry 7 = 255.
- R7: With `in_dual` = 1 at acceptance, channel 0 is decoded from `in_tile[63:0]` to `out_data[7:0]` and channel 1 from `in_tile[127:64]` to `out_data[15:8]`. Each channel picks its palette mode from its own endpoints.
- R8: With `in_dual` = 0 at acceptance, `in_tile[127:64]` has no effect and `out_data[15:8]` is 0 on every beat.
- R9: A tile presented during the beat of pixel 15 is accepted at that edge. Its pixel 0 follows in the very next cycle.
- R10: Changes on `in_tile`, `in_dual` or `in_valid` while `in_ready` is 0 do not alter the tile being output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Tile can be taken this cycle |
| in_dual | input | 1 | 1 = two channels, 0 = one channel |
| in_tile | input | 128 | Compressed tile(s), channel 0 in the low half |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Beat carries pixel 15 |
| out_data | output | 16 | Channel 1 in [15:8], channel 0 in [7:0] |

## Verification
A wrong pixel counter shows up in the very next beat as a value taken from the wrong selector, as a misplaced `out_last`, or as a beat missing from the sixteen. A palette mode that was picked wrongly, or one interpolation weight that is off, corrupts every pixel whose selector points at the affected entries. Tiles are therefore built so that every entry 0..7 is selected at least twice. A mode flag or tile capture that slips during streaming alters the upper byte or later pixels of the current tile. Held-off inputs are driven with the complement of the real tile, so such a slip becomes visible within one cycle.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int unsigned EP_W    = 8;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned PAL_N   = 1 << SEL_W;
    localparam int unsigned PIX_N   = 16;
    localparam int unsigned PIX_W   = $clog2(PIX_N);
    localparam int unsigned SELS_W  = PIX_N * SEL_W;
    localparam int unsigned CH_W    = 2 * EP_W + SELS_W;
    localparam int unsigned NCH     = 2;

    typedef logic [EP_W-1:0] val_t;

    typedef struct packed {
        logic [SELS_W-1:0] sels;
        val_t              ep_b;
        val_t              ep_a;
    } ch_tile_t;

    typedef logic [PAL_N-1:0][EP_W-1:0] pal_t;

    function automatic val_t blend(val_t a, val_t b, int unsigned wa,
                                   int unsigned wb, int unsigned div);
        logic [15:0] s;
        logic [15:0] q;
        s = 16'(wa) * {8'd0, a} + 16'(wb) * {8'd0, b};
        q = s / 16'(div);
        return q[EP_W-1:0];
    endfunction

endpackage

// File: rtl/scl_palette.sv
module scl_palette
    import scl_pkg::*;
(
    input  val_t ep_a,
    input  val_t ep_b,
    output pal_t pal
);
    logic wide;
    assign wide = ep_a > ep_b;

    assign pal[0] = ep_a;
    assign pal[1] = ep_b;

    for (genvar k = 2; k < PAL_N; k++) begin : g_ent
        val_t wide_v;
        val_t narrow_v;
        assign wide_v = blend(ep_a, ep_b, PAL_N - k, k - 1, PAL_N - 1);
        if (k < PAL_N - 2) begin : g_mix
            assign narrow_v = blend(ep_a, ep_b, PAL_N - 2 - k, k - 1, PAL_N - 3);
        end else if (k == PAL_N - 2) begin : g_lo
            assign narrow_v = '0;
        end else begin : g_hi
            assign narrow_v = '1;
        end
        assign pal[k] = wide ? wide_v : narrow_v;
    end
endmodule

// File: rtl/scl_lane.sv
module scl_lane
    import scl_pkg::*;
(
    input  ch_tile_t        tile,
    input  logic [PIX_W-1:0] pix,
    output val_t            val
);
    pal_t             pal;
    logic [SEL_W-1:0] sel;

    scl_palette u_pal (
        .ep_a (tile.ep_a),
        .ep_b (tile.ep_b),
        .pal  (pal)
    );

    assign sel = tile.sels[int'(pix) * SEL_W +: SEL_W];
    assign val = pal[sel];
endmodule

// File: rtl/scl_sequencer.sv
module scl_sequencer
    import scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             accept,
    output logic             out_valid,
    output logic             out_last,
    output logic [PIX_W-1:0] pix
);
    localparam logic [PIX_W-1:0] LAST = PIX_W'(PIX_N - 1);

    logic busy;

    assign out_valid = busy;
    assign out_last  = busy && (pix == LAST);
    assign in_ready  = !busy || (pix == LAST);
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pix  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            pix  <= '0;
        end else if (busy) begin
            if (pix == LAST) begin
                busy <= 1'b0;
            end else begin
                pix <= pix + 1'b1;
            end
        end
    end

    // R3
    start_pix0_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && pix == '0));

    // R3
    step_pix_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_valid && pix == $past(pix) + 1'b1));

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !in_ready);

    // R4
    end_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (!out_valid || pix == '0));
endmodule

// File: rtl/scl_tile_decoder.sv
module scl_tile_decoder
    import scl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_dual,
    input  logic [NCH*CH_W-1:0]  in_tile,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [NCH*EP_W-1:0]  out_data
);
    logic             accept;
    logic [PIX_W-1:0] pix;
    logic             dual_q;
    ch_tile_t         tile_q [NCH];

    scl_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid),
        .out_last  (out_last),
        .pix       (pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dual_q <= 1'b0;
        end else if (accept) begin
            dual_q <= in_dual;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        val_t lane_v;
        logic en;

        always_ff @(posedge clk) begin
            if (rst) begin
                tile_q[c] <= '0;
            end else if (accept) begin
                tile_q[c] <= in_tile[c*CH_W +: CH_W];
            end
        end

        scl_lane u_lane (
            .tile (tile_q[c]),
            .pix  (pix),
            .val  (lane_v)
        );

        if (c == 0) begin : g_base
            assign en = out_valid;
        end else begin : g_ext
            assign en = out_valid && dual_q;
        end

        assign out_data[c*EP_W +: EP_W] = en ? lane_v : '0;

        // R5
        wide_range_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && tile_q[c].ep_a > tile_q[c].ep_b) |->
            (lane_v <= tile_q[c].ep_a && lane_v >= tile_q[c].ep_b));

        // R6
        narrow_range_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && tile_q[c].ep_a <= tile_q[c].ep_b) |->
            (lane_v == 8'd0 || lane_v == 8'd255 ||
             (lane_v >= tile_q[c].ep_a && lane_v <= tile_q[c].ep_b)));
    end
endmodule

// File: tb/sim_scl_tile_decoder.sv
module sim_scl_tile_decoder;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic         in_dual;
    logic [127:0] in_tile;
    logic         out_valid;
    logic         out_last;
    logic [15:0]  out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    scl_tile_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dual(in_dual), .in_tile(in_tile), .out_valid(out_valid),
        .out_last(out_last), .out_data(out_data)
    );

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_val(logic [63:0] t, int p);
        int a, b, k, e;
        a = int'(t[7:0]);
        b = int'(t[15:8]);
        k = int'(t[16 + 3*p +: 3]);
        if (k == 0)      e = a;
        else if (k == 1) e = b;
        else if (a > b)  e = ((8 - k) * a + (k - 1) * b) / 7;
        else if (k <= 5) e = ((6 - k) * a + (k - 1) * b) / 5;
        else if (k == 6) e = 0;
        else             e = 255;
        return 8'(e);
    endfunction

    function automatic logic [15:0] exp_beat(logic [127:0] t, bit d, int p);
        if (d) return {ref_val(t[127:64], p), ref_val(t[63:0], p)};
        return {8'h00, ref_val(t[63:0], p)};
    endfunction

    function automatic logic [63:0] mk(logic [7:0] a, logic [7:0] b, int rot);
        logic [63:0] t;
        t[7:0]  = a;
        t[15:8] = b;
        for (int i = 0; i < 16; i++) t[16 + 3*i +: 3] = 3'((i + rot) % 8);
        return t;
    endfunction

    task automatic drive_accept(logic [127:0] t, bit d);
        in_valid = 1'b1;
        in_tile  = t;
        in_dual  = d;
        chk("R2", "ready when idle", 16'(in_ready), 16'd1);
        @(negedge clk);
        in_valid = 1'b0;
        in_tile  = '0;
    endtask

    task automatic check_stream(logic [127:0] t, bit d, string req, bit noise,
                                bit chain, logic [127:0] nt, bit nd);
        for (int i = 0; i < 16; i++) begin
            chk(req, $sformatf("pixel %0d data", i), out_data, exp_beat(t, d, i));
            chk("R3", $sformatf("pixel %0d valid", i), 16'(out_valid), 16'd1);
            chk("R4", $sformatf("pixel %0d last", i), 16'(out_last), 16'(i == 15));
            if (i < 15) begin
                if (noise) begin
                    in_valid = 1'b1;
                    in_tile  = ~t;
                    in_dual  = ~d;
                    chk("R2", "ready low while streaming", 16'(in_ready), 16'd0);
                end
            end else if (chain) begin
                in_valid = 1'b1;
                in_tile  = nt;
                in_dual  = nd;
                chk("R9", "ready on last beat", 16'(in_ready), 16'd1);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        if (!chain) chk("R4", "idle after last", 16'(out_valid), 16'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_dual = 1'b0; in_tile = '0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 16'(out_valid), 16'd0);
        chk("R1", "ready in reset", 16'(in_ready), 16'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", 16'(out_valid), 16'd0);
        chk("R1", "ready after reset", 16'(in_ready), 16'd1);
    endtask

    task automatic t_wide();
        logic [127:0] t = {64'hDEAD_BEEF_0123_4567, mk(8'd200, 8'd10, 0)};
        drive_accept(t, 1'b0);
        check_stream(t, 1'b0, "R5", 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_narrow();
        logic [127:0] t = {64'hFFFF_FFFF_FFFF_FFFF, mk(8'd30, 8'd220, 3)};
        drive_accept(t, 1'b0);
        check_stream(t, 1'b0, "R6", 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_equal();
        logic [127:0] t = {64'h0, mk(8'd77, 8'd77, 5)};
        drive_accept(t, 1'b0);
        check_stream(t, 1'b0, "R6", 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_extreme();
        logic [127:0] t = {mk(8'd0, 8'd255, 1), mk(8'd255, 8'd0, 6)};
        drive_accept(t, 1'b0);
        check_stream(t, 1'b0, "R8", 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_dual();
        logic [127:0] t = {mk(8'd12, 8'd250, 2), mk(8'd181, 8'd3, 7)};
        drive_accept(t, 1'b1);
        check_stream(t, 1'b1, "R7", 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_hold();
        logic [127:0] t = {mk(8'd90, 8'd40, 4), mk(8'd5, 8'd140, 0)};
        drive_accept(t, 1'b1);
        check_stream(t, 1'b1, "R10", 1'b1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_chain();
        logic [127:0] ta = {mk(8'd100, 8'd1, 3), mk(8'd64, 8'd128, 1)};
        logic [127:0] tb = {mk(8'd33, 8'd33, 0), mk(8'd240, 8'd16, 2)};
        drive_accept(ta, 1'b1);
        check_stream(ta, 1'b1, "R7", 1'b0, 1'b1, tb, 1'b0);
        in_valid = 1'b0;
        in_tile  = '0;
        check_stream(tb, 1'b0, "R9", 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_wide();
        t_narrow();
        t_equal();
        t_extreme();
        t_dual();
        t_hold();
        t_chain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule